// File: doc/BRIEF.md
# Serial ADC Result Output Controller

This block is the digital readout stage of a 16-bit sampling converter. It sits between an abstracted converter core and the serial pins. The core delivers a parallel two's complement result with a one-cycle done strobe. The block turns the chip-select and read/convert pins into two kinds of event. A convert event starts a new conversion. A read event starts the serial transfer of the result that was latched at the most recent done strobe.

Two clocking modes exist. In internal mode, every accepted convert also starts the transfer. The block then makes its own data clock by dividing the system clock, gives exactly 16 pulses, and holds the line low afterwards. In external mode, the data clock comes in on a pin. A read event arms a transfer that produces a one-period sync pulse and shifts on each rising data-clock edge. After the 16 result bits, the tag input comes out delayed by 16 clocks, which lets several converters share one line in a daisy chain. A pin selects straight binary or two's complement coding. A status output reports a fault condition, and a built-in-test input can force that condition.

All inputs are taken as synchronous to `clk`, except `dclk_in`, which passes through a two-stage synchronizer.

Top module: `adc_serial_readout`

## Requirements
- R1: A convert event is a falling edge of (`cs_n` OR `rd_conv`). This covers `rd_conv` falling while `cs_n` is low, and `cs_n` falling while `rd_conv` is low. An accepted convert event raises `conv_start` for exactly one cycle, on the clock edge after the event.
- R2: `busy` rises together with `conv_start` and stays high until the cycle after `conv_done`. A convert event that arrives while `busy` is high is ignored: it gives no `conv_start` and does not restart a transfer. `conv_result` is latched only on `conv_done`.
- R3: In internal mode (`mode_ext`=0), an accepted convert makes exactly 16 rising pulses on `dclk_out`, and `dclk_out` then stays low. In external mode, `dclk_out` stays low.
- R4: Serial bits go out MSB first. In internal mode, each bit is stable across both the rising and the falling edge of its `dclk_out` pulse.
- R5: In internal mode, once the 16 bits have been sent, `sdata` holds the `tag_in` level that was sampled on the edge that accepted the convert. Later changes of `tag_in` do not alter it.
- R6: The coding is chosen when a transfer starts. With `fmt_sb`=1 the bits sent are the latched result with bit 15 inverted (straight binary). With `fmt_sb`=0 the latched two's complement value goes out unchanged.
- R7: In external mode (`mode_ext`=1), a read event is a rising edge of (NOT `cs_n` AND `rd_conv`). The first rising `dclk_in` edge after it raises `sync` for one `dclk_in` period and puts result bit 15 on `sdata`. Each later rising edge puts out the next lower bit.
- R8: In external mode, from the 17th rising `dclk_in` edge onward, `sdata` equals the `tag_in` value sampled 16 rising edges earlier. This continues only while `cs_n` is low and `rd_conv` is high. After that, `sdata` holds its value.
- R9: `status` is high on the cycle after `fault_in` or `bist_force` is high, and low on the cycle after both are low.
- R10: After reset, `sdata`, `dclk_out`, `sync`, `busy`, `conv_start` and `status` are all 0, and the latched result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | Read/convert control |
| mode_ext | input | 1 | 1 = external data clock, 0 = internal |
| fmt_sb | input | 1 | 1 = straight binary, 0 = two's complement |
| tag_in | input | 1 | Daisy-chain tag input |
| dclk_in | input | 1 | External data clock |
| conv_done | input | 1 | Conversion finished strobe from core |
| conv_result | input | W | Two's complement result from core |
| fault_in | input | 1 | Fault condition from protection circuit |
| bist_force | input | 1 | Built-in test: force fault status |
| conv_start | output | 1 | One-cycle request to core to start a conversion |
| busy | output | 1 | Conversion in progress |
| sdata | output | 1 | Serial data |
| dclk_out | output | 1 | Generated data clock (internal mode) |
| sync | output | 1 | Frame sync (external mode) |
| status | output | 1 | Fault / invalid-data indicator |

## Verification
On every cycle, the assertions check the convert handshake: a start occurs only while idle and only after the combined select level has fallen, `busy` rises only with a start, and a done strobe clears `busy`. They also bound the number of generated clock pulses per transfer, confine `sync` to external mode, and tie the test input to the status output. Only the bench scenarios can show the serial content. That covers the MSB-first order of each coded word under both codings and across both edge paths that raise a convert event. It also covers which result is sent (the previous one), the held tag level after an internal transfer, the exact 16-clock delay of the tag in external mode, and the freeze of the data line when the read window closes.

// File: rtl/adc_ro_pkg.sv
package adc_ro_pkg;
  localparam int RO_RES_W = 16;
  localparam int RO_DCLK_DIV = 8;

  typedef enum logic {
    CODE_TWOS     = 1'b0,
    CODE_STRAIGHT = 1'b1
  } code_e;
endpackage

// File: rtl/adc_ro_event.sv
// Turns the select pins into convert and read events.
module adc_ro_event (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_conv,
  output logic conv_evt,
  output logic read_evt,
  output logic read_win
);
  logic cs_q, rd_q;
  logic gate_now, gate_prev, win_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
      rd_q <= rd_conv;
    end
  end

  always_comb begin
    gate_now  = cs_n | rd_conv;
    gate_prev = cs_q | rd_q;
    read_win  = ~cs_n & rd_conv;
    win_prev  = ~cs_q & rd_q;
    conv_evt  = gate_prev & ~gate_now;
    read_evt  = read_win & ~win_prev;
  end
endmodule

// File: rtl/adc_ro_conv.sv
// Busy tracking, convert request and result latch.
module adc_ro_conv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_evt,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  output logic         accept,
  output logic         conv_start,
  output logic         busy,
  output logic [W-1:0] held
);
  assign accept = conv_evt & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
      held       <= '0;
    end else begin
      conv_start <= accept;
      if (accept) begin
        busy <= 1'b1;
      end else if (busy && conv_done) begin
        busy <= 1'b0;
        held <= conv_result;
      end
    end
  end
endmodule

// File: rtl/adc_ro_shift.sv
// Serial transmitter for both clocking modes.
module adc_ro_shift #(
  parameter int W   = 16,
  parameter int DIV = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_ext,
  input  logic         int_start,
  input  logic         ext_start,
  input  logic         ext_window,
  input  logic         dclk_in,
  input  logic [W-1:0] word,
  input  logic         tag_in,
  output logic         sdata,
  output logic         dclk_out,
  output logic         sync
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] PH_HI   = PW'(DIV / 4);
  localparam logic [PW-1:0] PH_LO   = PW'(3 * (DIV / 4));
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  logic [2:0]    ds;
  logic          d_rise;
  logic [W-1:0]  sreg;
  logic [BW-1:0] bitcnt;
  logic [PW-1:0] ph;
  logic          tx_int, tx_ext, first, tag_hold;

  assign d_rise = ds[1] & ~ds[2];

  always_ff @(posedge clk) begin
    if (rst) ds <= '0;
    else     ds <= {ds[1:0], dclk_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      bitcnt   <= '0;
      ph       <= '0;
      tx_int   <= 1'b0;
      tx_ext   <= 1'b0;
      first    <= 1'b0;
      tag_hold <= 1'b0;
      sdata    <= 1'b0;
      dclk_out <= 1'b0;
      sync     <= 1'b0;
    end else if (int_start) begin
      sreg     <= {word[W-2:0], 1'b0};
      sdata    <= word[W-1];
      tag_hold <= tag_in;
      bitcnt   <= '0;
      ph       <= PW'(1);
      tx_int   <= 1'b1;
      tx_ext   <= 1'b0;
      dclk_out <= 1'b0;
      sync     <= 1'b0;
    end else if (ext_start) begin
      sreg     <= word;
      first    <= 1'b1;
      tx_ext   <= 1'b1;
      tx_int   <= 1'b0;
      dclk_out <= 1'b0;
      sync     <= 1'b0;
    end else begin
      if (tx_int) begin
        ph <= (ph == PH_LAST) ? '0 : ph + PW'(1);
        if (ph == PH_HI)      dclk_out <= 1'b1;
        else if (ph == PH_LO) dclk_out <= 1'b0;
        if (ph == PH_LAST) begin
          if (bitcnt == BIT_LAST) begin
            tx_int <= 1'b0;
            sdata  <= tag_hold;
          end else begin
            bitcnt <= bitcnt + BW'(1);
            sdata  <= sreg[W-1];
            sreg   <= {sreg[W-2:0], 1'b0};
          end
        end
      end
      if (tx_ext) begin
        if (!ext_window || !mode_ext) begin
          tx_ext <= 1'b0;
          sync   <= 1'b0;
        end else if (d_rise) begin
          sdata <= sreg[W-1];
          sreg  <= {sreg[W-2:0], tag_in};
          sync  <= first;
          first <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
  import adc_ro_pkg::*;
#(
  parameter int W   = RO_RES_W,
  parameter int DIV = RO_DCLK_DIV
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_conv,
  input  logic         mode_ext,
  input  logic         fmt_sb,
  input  logic         tag_in,
  input  logic         dclk_in,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  input  logic         fault_in,
  input  logic         bist_force,
  output logic         conv_start,
  output logic         busy,
  output logic         sdata,
  output logic         dclk_out,
  output logic         sync,
  output logic         status
);
  logic         conv_evt, read_evt, read_win, accept;
  logic [W-1:0] held, coded;
  code_e        code_sel;

  adc_ro_event u_event (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_conv(rd_conv),
    .conv_evt(conv_evt), .read_evt(read_evt), .read_win(read_win)
  );

  adc_ro_conv #(.W(W)) u_conv (
    .clk(clk), .rst(rst), .conv_evt(conv_evt), .conv_done(conv_done),
    .conv_result(conv_result), .accept(accept), .conv_start(conv_start),
    .busy(busy), .held(held)
  );

  always_comb begin
    code_sel = code_e'(fmt_sb);
    coded    = held;
    if (code_sel == CODE_STRAIGHT) coded[W-1] = ~held[W-1];
  end

  adc_ro_shift #(.W(W), .DIV(DIV)) u_shift (
    .clk(clk), .rst(rst), .mode_ext(mode_ext),
    .int_start(accept & ~mode_ext), .ext_start(read_evt & mode_ext),
    .ext_window(read_win), .dclk_in(dclk_in), .word(coded), .tag_in(tag_in),
    .sdata(sdata), .dclk_out(dclk_out), .sync(sync)
  );

  always_ff @(posedge clk) begin
    if (rst) status <= 1'b0;
    else     status <= fault_in | bist_force;
  end
endmodule

// File: rtl/adc_ro_chk.sv
module adc_ro_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic rd_conv,
  input logic mode_ext,
  input logic conv_done,
  input logic bist_force,
  input logic conv_start,
  input logic busy,
  input logic dclk_out,
  input logic sync,
  input logic status
);
  logic [5:0] rise_cnt;
  logic       dclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt  <= '0;
      dclk_prev <= 1'b0;
    end else begin
      dclk_prev <= dclk_out;
      if (conv_start)                                      rise_cnt <= '0;
      else if (dclk_out && !dclk_prev && rise_cnt != 6'd63) rise_cnt <= rise_cnt + 6'd1;
    end
  end

  assert_start_after_fall_R1: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(!cs_n && !rd_conv));
  assert_start_only_idle_R2: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !$past(busy));
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> conv_start);
  assert_done_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done && !conv_start) |=> !busy);
  assert_pulse_limit_R3: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= 6'd16);
  assert_sync_ext_only_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sync) |-> $past(mode_ext));
  assert_bist_status_R9: assert property (@(posedge clk) disable iff (rst)
    bist_force |=> status);
endmodule

bind adc_serial_readout adc_ro_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_conv(rd_conv), .mode_ext(mode_ext),
  .conv_done(conv_done), .bist_force(bist_force), .conv_start(conv_start),
  .busy(busy), .dclk_out(dclk_out), .sync(sync), .status(status)
);

// File: tb/adc_serial_readout_tb.sv
module adc_serial_readout_tb;
  localparam int W = 16;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_conv = 1'b1, mode_ext = 1'b0, fmt_sb = 1'b0;
  logic tag_in = 1'b0, dclk_in = 1'b0, conv_done, fault_in = 1'b0, bist_force = 1'b0;
  logic [W-1:0] conv_result;
  logic conv_start, busy, sdata, dclk_out, sync, status;

  int checks = 0, failures = 0, n_starts = 0, n_rises = 0, cd_cnt = 0;
  bit finished = 1'b0;
  logic [W-1:0] core_val = '0;
  logic [W-1:0] last = '0;

  always #2.5 clk = ~clk;

  adc_serial_readout #(.W(W), .DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_conv(rd_conv), .mode_ext(mode_ext),
    .fmt_sb(fmt_sb), .tag_in(tag_in), .dclk_in(dclk_in), .conv_done(conv_done),
    .conv_result(conv_result), .fault_in(fault_in), .bist_force(bist_force),
    .conv_start(conv_start), .busy(busy), .sdata(sdata), .dclk_out(dclk_out),
    .sync(sync), .status(status)
  );

  assign conv_result = core_val;

  // Converter core model: done strobe 20 cycles after a start.
  always @(posedge clk) begin
    if (rst) begin
      cd_cnt <= 0; conv_done <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        cd_cnt <= 20; n_starts <= n_starts + 1;
      end else if (cd_cnt != 0) begin
        cd_cnt <= cd_cnt - 1;
        if (cd_cnt == 1) conv_done <= 1'b1;
      end
    end
  end

  always @(posedge dclk_out) n_rises <= n_rises + 1;

  function automatic logic [W-1:0] code(input logic [W-1:0] v, input logic sb);
    return sb ? W'((32'(v) + 32'h8000) % 32'h10000) : v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Internal-mode transfer: convert via rd or cs edge, check previous result.
  task automatic int_xfer(input logic [W-1:0] nxt, input logic sb, input logic tg, input bit via_cs);
    logic [W-1:0] exp, c1, c2;
    int s0, r0;
    exp = code(last, sb);
    s0 = n_starts; r0 = n_rises;
    @(negedge clk); cs_n = 1'b1; rd_conv = 1'b1; core_val = nxt; fmt_sb = sb; tag_in = tg;
    cyc(2);
    if (via_cs) begin rd_conv = 1'b0; cyc(1); cs_n = 1'b0; end
    else begin cs_n = 1'b0; cyc(1); rd_conv = 1'b0; end
    @(negedge clk); tag_in = ~tg;
    chk(conv_start === 1'b1, via_cs ? "R1 cs-edge conv_start" : "R1 rd-edge conv_start", 32'(conv_start), 1);
    for (int b = W - 1; b >= 0; b--) begin
      @(posedge dclk_out); @(negedge clk); c1[b] = sdata;
      @(negedge dclk_out); @(negedge clk); c2[b] = sdata;
    end
    chk(c1 === exp, "R4/R6 word at rising edges", 32'(c1), 32'(exp));
    chk(c2 === exp, "R4 word at falling edges", 32'(c2), 32'(exp));
    cyc(3 * DIV);
    chk(n_rises - r0 == 16 && dclk_out == 1'b0, "R3 pulse count", 32'(n_rises - r0), 16);
    chk(sdata === tg, "R5 held tag", 32'(sdata), 32'(tg));
    chk(n_starts - s0 == 1 && !busy, "R2 one start per convert", 32'(n_starts - s0), 1);
    last = nxt;
  endtask

  task automatic ext_rise(input logic tg, output logic d, output logic s);
    @(negedge clk); tag_in = tg;
    @(negedge clk); dclk_in = 1'b1;
    cyc(8); d = sdata; s = sync;
    dclk_in = 1'b0;
    cyc(4);
  endtask

  localparam logic [23:0] TPAT = 24'hB35AC6;
  localparam logic [W-1:0] VALS [6] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h1234, 16'hFFFF, 16'hA5C3};

  initial begin
    logic [W-1:0] cap, exp;
    logic [7:0] tcap;
    logic d, s, s0r, s1r;
    int st0;
    cyc(4); rst = 1'b0; cyc(1);
    // R10 reset state
    chk({sdata, dclk_out, sync, busy, conv_start, status} === 6'b0, "R10 reset outputs",
        32'({sdata, dclk_out, sync, busy, conv_start, status}), 0);

    // Internal mode sweep over values, both codings, both edge paths
    for (int i = 0; i < 12; i++)
      int_xfer(VALS[i % 6], logic'(i % 2), logic'((i / 2) % 2), bit'((i / 3) % 2));
    int_xfer(16'h0F0F, 1'b0, 1'b1, 1'b0);  // flush last sweep value

    // R2: convert while busy is ignored
    @(negedge clk); cs_n = 1'b0; rd_conv = 1'b1; core_val = 16'h4321; cyc(2);
    st0 = n_starts;
    rd_conv = 1'b0; cyc(3); rd_conv = 1'b1; cyc(1); rd_conv = 1'b0; cyc(2);
    chk(n_starts - st0 == 1 && busy, "R2 busy convert ignored", 32'(n_starts - st0), 1);
    cyc(16 * DIV + 40);
    last = 16'h4321;
    int_xfer(16'h1111, 1'b0, 1'b0, 1'b0);

    // External mode
    @(negedge clk); mode_ext = 1'b1; cs_n = 1'b1; rd_conv = 1'b1; fmt_sb = 1'b1; core_val = 16'h3C5A;
    st0 = n_rises;
    cyc(2); cs_n = 1'b0; cyc(2); rd_conv = 1'b0; cyc(40);
    exp = code(16'h3C5A, 1'b1);
    rd_conv = 1'b1; cyc(2);  // read event: rising rd with cs low
    for (int k = 0; k < 16; k++) begin
      ext_rise(TPAT[k], d, s);
      cap[W-1-k] = d;
      if (k == 0) s0r = s;
      if (k == 1) s1r = s;
    end
    chk(cap === exp, "R7/R6 external word", 32'(cap), 32'(exp));
    chk(s0r === 1'b1 && s1r === 1'b0, "R7 sync one period", 32'({s0r, s1r}), 2);
    for (int k = 16; k < 24; k++) begin
      ext_rise(TPAT[k], d, s);
      tcap[k - 16] = d;
    end
    chk(tcap === TPAT[7:0], "R8 tag delayed by 16", 32'(tcap), 32'(TPAT[7:0]));
    chk(n_rises == st0, "R3 no dclk_out in external mode", 32'(n_rises - st0), 0);
    // window closes: data frozen
    @(negedge clk); cs_n = 1'b1; cyc(2);
    d = sdata;
    ext_rise(~d, s0r, s1r); ext_rise(~d, s0r, s1r);
    chk(sdata === d, "R8 frozen after window", 32'(sdata), 32'(d));
    // read via falling cs with rd high
    @(negedge clk); cs_n = 1'b0; cyc(2);
    ext_rise(1'b0, d, s);
    chk(s === 1'b1 && d === exp[W-1], "R7 cs-edge read", 32'({s, d}), 32'({1'b1, exp[W-1]}));
    @(negedge clk); cs_n = 1'b1; mode_ext = 1'b0; cyc(4);

    // R9 status
    @(negedge clk); bist_force = 1'b1; @(negedge clk);
    chk(status === 1'b1, "R9 bist forces status", 32'(status), 1);
    bist_force = 1'b0; @(negedge clk);
    chk(status === 1'b0, "R9 status clears", 32'(status), 0);
    fault_in = 1'b1; @(negedge clk);
    chk(status === 1'b1, "R9 fault sets status", 32'(status), 1);
    fault_in = 1'b0; cyc(2);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule